// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the transfers of one DMA channel. Software programs a transfer count and a control word holding an enable bit and a two-bit mode field. The sequencer then raises a transfer request toward a datapath and waits for a one-cycle completion pulse. Address generation, bus arbitration and the movement of data belong to that datapath and are not part of this block.

There are two kinds of operation. In a block mode the channel runs on its own: it issues a request, decrements the counter when the transfer completes, and sets its done flag when the counter reaches zero. In single-word mode, each pulse on an external demand input produces one transfer, and the counter plays no part.

Clearing the enable bit never cuts a transfer short. The channel finishes the transfer in flight and only then reports done. The counter is protected: a write to it takes effect only while the channel is idle or in single-word mode.

Top module: `xfer_sequencer`

## Requirements
- R1: After reset the channel has enable 0, done 1, counter 0, mode 0 and no request raised.
- R2: A control write (`wr_sel_i`=0) loads enable from data bit 0 and mode from data bits 2:1. A write with enable 1 while done is 1 starts the channel. In a block mode with a nonzero counter, starting clears done and raises the request at the same clock edge that stores the write.
- R3: Once raised, the request stays high until a cycle in which `xfer_done_i` is high.
- R4: Modes 0, 1 and 2 are block modes. In a block mode each completion decrements the counter by one and drops the request for one cycle. If the count is still nonzero and the channel is still enabled, the request rises again on the following edge.
- R5: In a block mode, a completion that brings the counter to zero sets done, and no further request is raised.
- R6: Starting a block mode with a counter of zero sets done at once and raises no request.
- R7: Mode 2'b11 is single-word mode. While enabled and not done, each `dreq_i` high with no request pending raises the request on the next edge. Completions leave both the counter and done unchanged.
- R8: A counter write (`wr_sel_i`=1) is accepted only when enable is 0 and done is 1, or when the mode is 2'b11. At any other time the write is ignored and the counter keeps its value.
- R9: Clearing enable while a request is pending leaves done at 0 until the completion pulse, and done is set at that completion. Clearing enable with no request pending sets done at the edge that stores the write.
- R10: Done and the request are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects control, 1 selects counter |
| wr_data_i | input | CNT_W | Write data |
| dreq_i | input | 1 | External demand for single-word mode |
| xfer_done_i | input | 1 | One-cycle completion pulse from the datapath |
| xfer_req_o | output | 1 | Transfer request to the datapath |
| done_o | output | 1 | Channel done flag |
| enable_o | output | 1 | Stored enable bit |
| mode_o | output | 2 | Stored mode field |
| count_o | output | CNT_W | Transfers remaining |

## Verification
Every output comes from a register, so each result is due exactly one clock edge after the input that causes it. A write, a completion pulse or a demand pulse is reflected at the first rising edge that samples it. In a block mode the request rises again one edge after that. The bench drives inputs on falling edges and reads outputs on the following falling edge. It also steps through the one-cycle gap between block transfers explicitly, checking that the request is low there and high one edge later.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
  typedef logic [1:0] xfer_mode_t;
  localparam xfer_mode_t MODE_SINGLE = 2'b11;

  function automatic logic is_block(input xfer_mode_t m);
    return m != MODE_SINGLE;
  endfunction
endpackage

// File: rtl/xs_ctrl.sv
module xs_ctrl
  import xfer_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_ctrl,
  input  logic [2:0] ctrl_bits,
  output logic       en_q,
  output xfer_mode_t mode_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= '0;
    end else if (wr_ctrl) begin
      en_q   <= ctrl_bits[0];
      mode_q <= ctrl_bits[2:1];
    end
  end

  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> (en_q == $past(ctrl_bits[0])) && (mode_q == $past(ctrl_bits[2:1])));
endmodule

// File: rtl/xs_counter.sv
module xs_counter
  import xfer_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             en_q,
  input  logic             done_q,
  input  xfer_mode_t       mode_q,
  input  logic             completed,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cnt_zero,
  output logic             cnt_one
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic wr_ok;
  assign wr_ok    = wr_cnt && ((!en_q && done_q) || !is_block(mode_q));
  assign cnt_zero = (cnt_q == '0);
  assign cnt_one  = (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (wr_ok)
      cnt_q <= wr_data;
    else if (completed && is_block(mode_q))
      cnt_q <= cnt_q - ONE;
  end

  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    (completed && is_block(mode_q) && !wr_cnt) |=> cnt_q == $past(cnt_q) - ONE);
  a_r7_single_keeps: assert property (@(posedge clk) disable iff (rst)
    (!is_block(mode_q) && !wr_cnt) |=> $stable(cnt_q));
  a_r8_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt && en_q && !done_q && is_block(mode_q) && !completed) |=> $stable(cnt_q));
endmodule

// File: rtl/xs_engine.sv
module xs_engine
  import xfer_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       stop,
  input  logic       new_block,
  input  logic       en_q,
  input  xfer_mode_t mode_q,
  input  logic       cnt_zero,
  input  logic       cnt_one,
  input  logic       dreq,
  input  logic       xfer_done,
  output logic       req_q,
  output logic       done_q,
  output logic       completed
);
  logic last;
  assign completed = req_q && xfer_done;
  assign last      = is_block(mode_q) && cnt_one;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      done_q <= 1'b1;
    end else if (start) begin
      done_q <= new_block && cnt_zero;
      req_q  <= new_block && !cnt_zero;
    end else if (completed) begin
      req_q <= 1'b0;
      if (stop || !en_q || last) done_q <= 1'b1;
    end else if (stop) begin
      if (!req_q) done_q <= 1'b1;
    end else if (en_q && !done_q && !req_q) begin
      if (is_block(mode_q)) req_q <= !cnt_zero;
      else                  req_q <= dreq;
    end
  end

  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req_q && !xfer_done) |=> req_q);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(req_q && done_q));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start) |=> !req_q);
  a_r9_stop_after_xfer: assert property (@(posedge clk) disable iff (rst)
    (completed && !en_q) |=> done_q);
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer
  import xfer_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             dreq_i,
  input  logic             xfer_done_i,
  output logic             xfer_req_o,
  output logic             done_o,
  output logic             enable_o,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] count_o
);
  logic       wr_ctrl, wr_cnt, en_q, done_q, req_q, completed;
  logic       cnt_zero, cnt_one, start, stop;
  xfer_mode_t mode_q;

  assign wr_ctrl = wr_en_i && !wr_sel_i;
  assign wr_cnt  = wr_en_i && wr_sel_i;
  assign start   = wr_ctrl && wr_data_i[0] && done_q;
  assign stop    = wr_ctrl && !wr_data_i[0] && !done_q;

  xs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .ctrl_bits(wr_data_i[2:0]),
    .en_q(en_q), .mode_q(mode_q)
  );

  xs_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr_cnt(wr_cnt), .wr_data(wr_data_i),
    .en_q(en_q), .done_q(done_q), .mode_q(mode_q), .completed(completed),
    .cnt_q(count_o), .cnt_zero(cnt_zero), .cnt_one(cnt_one)
  );

  xs_engine u_eng (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .new_block(is_block(wr_data_i[2:1])), .en_q(en_q), .mode_q(mode_q),
    .cnt_zero(cnt_zero), .cnt_one(cnt_one), .dreq(dreq_i),
    .xfer_done(xfer_done_i), .req_q(req_q), .done_q(done_q),
    .completed(completed)
  );

  assign xfer_req_o = req_q;
  assign done_o     = done_q;
  assign enable_o   = en_q;
  assign mode_o     = mode_q;
endmodule

// File: tb/xfer_sequencer_tb_top.sv
module xfer_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_sel = 1'b0, dreq = 1'b0, xdone = 1'b0;
  logic [CNT_W-1:0] wr_data = '0;
  logic xfer_req, done, enable;
  logic [1:0] mode;
  logic [CNT_W-1:0] count;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_sequencer #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .dreq_i(dreq), .xfer_done_i(xdone),
    .xfer_req_o(xfer_req), .done_o(done), .enable_o(enable),
    .mode_o(mode), .count_o(count)
  );

  task automatic chk(input string req, input string what,
                     input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic en, input logic [1:0] m);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = {{(CNT_W-3){1'b0}}, m, en};
    cyc(); wr_en = 1'b0;
  endtask

  task automatic wr_count(input logic [CNT_W-1:0] v);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = v;
    cyc(); wr_en = 1'b0;
  endtask

  task automatic complete();
    xdone = 1'b1; cyc(); xdone = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "enable", enable, 0);
    chk("R1", "done", done, 1);
    chk("R1", "count", count, 0);
    chk("R1", "mode", mode, 0);
    chk("R1", "req", xfer_req, 0);
  endtask

  task automatic t_block_run();
    wr_count(3);
    chk("R8", "idle write accepted", count, 3);
    wr_ctrl(1'b1, 2'b01);
    chk("R2", "enable", enable, 1);
    chk("R2", "mode", mode, 1);
    chk("R2", "done cleared", done, 0);
    chk("R2", "req on start", xfer_req, 1);
    wr_count(9);
    chk("R8", "busy write ignored", count, 3);
    cyc(2);
    chk("R3", "req held", xfer_req, 1);
    for (int k = 2; k >= 1; k--) begin
      complete();
      chk("R4", "decrement", count, k);
      chk("R4", "gap cycle", xfer_req, 0);
      cyc();
      chk("R4", "reissue", xfer_req, 1);
    end
    complete();
    chk("R5", "count zero", count, 0);
    chk("R5", "done set", done, 1);
    cyc(3);
    chk("R5", "no further req", xfer_req, 0);
    chk("R10", "done excludes req", done & xfer_req, 0);
  endtask

  task automatic t_zero_start();
    wr_ctrl(1'b0, 2'b00);
    wr_count(0);
    wr_ctrl(1'b1, 2'b00);
    chk("R6", "done at once", done, 1);
    chk("R6", "no req", xfer_req, 0);
    cyc(2);
    chk("R6", "still no req", xfer_req, 0);
  endtask

  task automatic t_single();
    wr_ctrl(1'b0, 2'b00);
    wr_count(4);
    wr_ctrl(1'b1, 2'b11);
    chk("R7", "no req before demand", xfer_req, 0);
    chk("R7", "done cleared", done, 0);
    wr_count(7);
    chk("R8", "single-word write accepted", count, 7);
    cyc(2);
    chk("R7", "idle without demand", xfer_req, 0);
    dreq = 1'b1; cyc(); dreq = 1'b0;
    chk("R7", "req on demand", xfer_req, 1);
    complete();
    chk("R7", "count unchanged", count, 7);
    chk("R7", "done stays 0", done, 0);
    chk("R7", "req dropped", xfer_req, 0);
    wr_ctrl(1'b0, 2'b11);
    chk("R9", "idle stop sets done", done, 1);
  endtask

  task automatic t_stop_inflight();
    wr_count(4);
    wr_ctrl(1'b1, 2'b00);
    chk("R9", "running", xfer_req, 1);
    wr_ctrl(1'b0, 2'b00);
    chk("R9", "enable cleared", enable, 0);
    chk("R9", "done waits", done, 0);
    chk("R9", "req kept", xfer_req, 1);
    cyc(2);
    chk("R9", "done still waits", done, 0);
    complete();
    chk("R9", "done after completion", done, 1);
    chk("R9", "req off", xfer_req, 0);
    chk("R9", "count after stop", count, 3);
    cyc(2);
    chk("R9", "no restart", xfer_req, 0);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc();
    t_reset();
    t_block_run();
    t_zero_start();
    t_single();
    t_stop_inflight();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule